// File: doc/BRIEF.md
# Parallel-Load Serial-Out Byte Shifter

This block captures a byte from eight parallel inputs and presents it one bit at a time on a serial output, with the most significant bit first. It models a classic load-and-shift input expander, but everything runs on a single system clock. The external shift clock pin and the active-low enable pin are sampled like any other data input.

A low level on the active-low load input copies the parallel byte into all stages. While load is low, the serial output follows the top parallel bit combinationally. With load high, the two pins are first synchronised and then combined into a gated clock, the OR of the shift clock and the enable. Each rising edge of that gated clock moves the register one place toward the output. The serial input fills the vacated bottom stage. A second output always carries the inverse of the serial output.

A two-state edge machine tracks the gated clock. It has two states:
- `GATE_HIGH`: the gated clock was last seen high.
- `GATE_LOW`: the gated clock was last seen low; the edge is armed.

It has four transitions:
- **arm**: HIGH to LOW when the gated clock falls.
- **fire**: LOW to HIGH on a rise with load high; this emits one shift pulse.
- **swallow**: LOW to HIGH on a rise with load low; no pulse is emitted.
- **stay**: the state is kept when the gated clock does not change.

Top module: `piso_reg8`

## Requirements
- R1: An asynchronous active-low reset clears every stage to 0, so the serial output reads 0 and its complement reads 1. Reset also puts the edge machine in `GATE_HIGH` with both synchronisers at 1, so no shift follows the release of reset.
- R2: On each system-clock edge while `load_n` is 0, every stage takes the parallel input. This happens whatever the shift clock and enable pins do. After `load_n` returns to 1, the loaded byte is kept until a shift.
- R3: While `load_n` is 0, `ser_out` equals `par_in[7]` combinationally, and a change of that bit reaches `ser_out` with no clock edge.
- R4: With `load_n` at 1 and `sh_en_n` at 0, a rising edge on `sh_clk` shifts the register once. Stage 0 takes `ser_in` and stage n takes stage n-1. The new value shows on `ser_out` after the third system-clock edge that follows the pin change.
- R5: With `load_n` at 1 and `sh_clk` at 0, a rising edge on `sh_en_n` causes the same single shift as a clock-pin edge.
- R6: While either `sh_clk` or `sh_en_n` is held at 1, toggling the other pin never shifts, and the outputs stay unchanged.
- R7: `ser_out_n` is always the inverse of `ser_out`.
- R8: A rising edge of the gated clock that the edge machine sees while `load_n` is 0 is discarded. It causes no shift after load returns high.
- R9: Each rising edge of the gated clock gives exactly one shift. This includes both pins rising in the same cycle, and a shift pulse never lasts two cycles.
- R10: After a load, successive shifts present bits 7 down to 0 on `ser_out`. The bits fed on `ser_in` then follow in the order they were fed, each appearing 8 shifts after it was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| sh_clk | input | 1 | Shift clock pin, asynchronous to `clk` |
| sh_en_n | input | 1 | Active-low shift enable pin, ORed with the shift clock |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel byte; bit 7 is nearest the output |
| ser_out | output | 1 | Last stage, or `par_in[7]` while loading |
| ser_out_n | output | 1 | Inverse of `ser_out` |

## Verification
A pin change becomes visible at the output after three system-clock edges: two synchroniser flops and then the stage register. The bench therefore drives pins on falling edges and waits four rising edges before it samples on a falling edge. Load effects on the output are combinational and are checked one time step after the drive. The loaded word is checked after it is held through release. Each hold and discard case waits the same four-edge window, so a missed or extra shift would already have shown at the output.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Last observed level of the gated shift clock.
    typedef enum logic {
        GATE_HIGH = 1'b0,
        GATE_LOW  = 1'b1
    } gate_state_t;

    localparam int unsigned DEFAULT_WIDTH  = 8;
    localparam int unsigned DEFAULT_SYNC   = 2;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pin_s
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign pin_s = chain[STAGES-1];

endmodule

// File: rtl/gate_edge_fsm.sv
module gate_edge_fsm
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gated,
    input  logic load_n,
    output logic shift_pulse
);

    gate_state_t state_q;
    gate_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_HIGH;
        else        state_q <= state_d;
    end

    // Transitions: arm, fire, swallow, stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_HIGH: if (!gated) state_d = GATE_LOW;   // arm
            GATE_LOW:  if (gated)  state_d = GATE_HIGH;  // fire or swallow
        endcase
    end

    // Outputs: a pulse only on fire (rise seen with load high).
    always_comb begin
        shift_pulse = 1'b0;
        unique case (state_q)
            GATE_HIGH: shift_pulse = 1'b0;
            GATE_LOW:  shift_pulse = gated && load_n;
        endcase
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);

    // R8
    load_blocks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !shift_pulse);

endmodule

// File: rtl/stage_chain.sv
module stage_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             shift,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stages
);

    localparam int unsigned TOP = WIDTH - 1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic shift_src;
            if (i == 0) begin : g_head
                assign shift_src = ser_in;
            end else begin : g_body
                assign shift_src = stages[i-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stages[i] <= 1'b0;
                else if (!load_n) stages[i] <= par_in[i];
                else if (shift)  stages[i] <= shift_src;
            end
        end
    endgenerate

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> stages == $past(par_in));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift) |=> stages == {$past(stages[TOP-1:0]), $past(ser_in)});

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !shift) |=> $stable(stages));

endmodule

// File: rtl/piso_reg8.sv
module piso_reg8
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH       = DEFAULT_WIDTH,
    parameter int unsigned SYNC_STAGES = DEFAULT_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             sh_clk,
    input  logic             sh_en_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out,
    output logic             ser_out_n
);

    localparam int unsigned TOP = WIDTH - 1;

    logic             clk_pin_s;
    logic             en_pin_s;
    logic             gated;
    logic             shift_pulse;
    logic [WIDTH-1:0] stages;

    pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_clk_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sh_clk),
        .pin_s (clk_pin_s)
    );

    pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_en_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sh_en_n),
        .pin_s (en_pin_s)
    );

    assign gated = clk_pin_s | en_pin_s;

    gate_edge_fsm u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .gated       (gated),
        .load_n      (load_n),
        .shift_pulse (shift_pulse)
    );

    stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .shift  (shift_pulse),
        .ser_in (ser_in),
        .par_in (par_in),
        .stages (stages)
    );

    always_comb begin
        ser_out   = load_n ? stages[TOP] : par_in[TOP];
        ser_out_n = ~ser_out;
    end

    // R3
    load_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> ser_out == par_in[TOP]);

    // R1
    post_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !shift_pulse);

endmodule

// File: tb/test_piso_reg8.sv
module test_piso_reg8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_n;
    logic       sh_clk;
    logic       sh_en_n;
    logic       ser_in;
    logic [7:0] par_in;
    logic       ser_out;
    logic       ser_out_n;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [7:0]  model;

    always #4 clk = ~clk;

    piso_reg8 i_piso_reg8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .sh_clk    (sh_clk),
        .sh_en_n   (sh_en_n),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .ser_out   (ser_out),
        .ser_out_n (ser_out_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string req, input logic exp);
        chk(req, ser_out, exp);
        chk({req, "/R7"}, ser_out_n, ~exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] b);
        par_in = b;
        load_n = 1'b0;
        wait_cyc(2);
        load_n = 1'b1;
        wait_cyc(1);
        model = b;
    endtask

    // Rising edge on the clock pin, then return low (enable is low).
    task automatic pulse_clk(input logic sin);
        ser_in = sin;
        sh_clk = 1'b1;
        wait_cyc(4);
        model  = {model[6:0], sin};
        sh_clk = 1'b0;
        wait_cyc(4);
    endtask

    // Rising edge on the enable pin with clock pin low, then back low.
    task automatic pulse_en(input logic sin);
        ser_in  = sin;
        sh_en_n = 1'b1;
        wait_cyc(4);
        model   = {model[6:0], sin};
        sh_en_n = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_reset;
        chk_out("R1 reset value", 1'b0);
        wait_cyc(6);
        chk_out("R1 no shift after release", 1'b0);
    endtask

    task automatic t_load_passthru;
        par_in = 8'h80;
        load_n = 1'b0;
        #1;
        chk_out("R3 passthru high", 1'b1);
        par_in = 8'h7F;
        #1;
        chk_out("R3 passthru low", 1'b0);
        par_in = 8'hC3;
        sh_clk = 1'b1;              // clock activity during load
        wait_cyc(5);
        sh_clk = 1'b0;
        wait_cyc(4);
        load_n = 1'b1;
        wait_cyc(2);
        model = 8'hC3;
        chk_out("R2 loaded word held", model[7]);
    endtask

    task automatic t_shift_mixed;
        logic [7:0] b;
        logic [7:0] sbits;
        b     = 8'hB4;
        sbits = 8'b0110_1101;
        do_load(b);
        for (int i = 0; i < 8; i++) begin
            chk_out("R10 parallel bit order", b[7-i]);
            if (i % 2 == 0) pulse_clk(sbits[7-i]);
            else            pulse_en(sbits[7-i]);
            chk_out((i % 2 == 0) ? "R4 clock-pin shift" : "R5 enable-pin shift", model[7]);
        end
        for (int i = 0; i < 8; i++) begin
            chk_out("R10 serial bits after eight shifts", sbits[7-i]);
            pulse_clk(1'b0);
        end
    endtask

    task automatic t_hold;
        do_load(8'hA5);
        // Enable rises with clock low: one shift, then hold.
        ser_in  = 1'b1;
        sh_en_n = 1'b1;
        wait_cyc(4);
        model = {model[6:0], 1'b1};
        chk_out("R5 enable edge before hold", model[7]);
        for (int i = 0; i < 3; i++) begin
            sh_clk = 1'b1; wait_cyc(4);
            sh_clk = 1'b0; wait_cyc(4);
            chk_out("R6 enable high holds", model[7]);
        end
        sh_clk = 1'b1;              // clock high now, enable falls: no rise
        wait_cyc(4);
        sh_en_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < 3; i++) begin
            sh_en_n = 1'b1; wait_cyc(4);
            sh_en_n = 1'b0; wait_cyc(4);
            chk_out("R6 clock high holds", model[7]);
        end
        sh_clk = 1'b0;
        wait_cyc(4);
        pulse_clk(1'b0);
        chk_out("R6 shifting resumes", model[7]);
    endtask

    task automatic t_load_priority;
        par_in = 8'h5A;             // bit7=0, bit6=1
        load_n = 1'b0;
        sh_clk = 1'b1;
        wait_cyc(5);
        load_n = 1'b1;
        wait_cyc(4);
        model = 8'h5A;
        chk_out("R8 edge under load discarded", 1'b0);
        sh_clk = 1'b0;
        wait_cyc(4);
        chk_out("R8 no late shift", 1'b0);
        pulse_clk(1'b0);
        chk_out("R8 next edge shifts once", 1'b1);
    endtask

    task automatic t_simultaneous;
        do_load(8'h90);             // 1001_0000
        sh_clk  = 1'b1;
        sh_en_n = 1'b1;
        ser_in  = 1'b0;
        wait_cyc(6);
        model = {model[6:0], 1'b0};
        chk_out("R9 both pins one shift", model[7]);
        sh_clk  = 1'b0;
        sh_en_n = 1'b0;
        wait_cyc(4);
        pulse_en(1'b0);
        chk_out("R9 following edge", model[7]);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        load_n  = 1'b1;
        sh_clk  = 1'b0;
        sh_en_n = 1'b0;
        ser_in  = 1'b0;
        par_in  = 8'h00;
        model   = 8'h00;
        wait_cyc(3);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset();
        t_load_passthru();
        t_shift_mixed();
        t_hold();
        t_load_priority();
        t_simultaneous();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    task automatic t_reset_pre;
        chk_out("R1 during reset", 1'b0);
    endtask

endmodule